// File: doc/BRIEF.md
# Instruction Reuse Filter Table

This block learns, for each memory instruction, how often the data it touches turns out to be reused. The block holds a direct-mapped array of 512 eight-bit saturating counters. The array is indexed by a fold of the instruction's word address.

A separate access-tracking block reports two kinds of event. A reuse event moves the counter for that instruction up, and a first-touch event moves it down. The insertion logic of a cache queries the table with the address of the instruction that caused a miss. One cycle later it receives one of five classes, ordered from "always bypass" to "strong reuse". The lookup port and the update port both accept one request every cycle.

After reset, a small state machine runs first. In state SWEEP it writes the start value 128 into every entry, one entry per cycle. It then moves, by the transition SWEEP_DONE, into state SERVE and stays there until the next reset. While SWEEP runs, the ready output is low, updates are ignored, and every lookup answers NORMAL.

Top module: `reuse_filter_table`

## Requirements
- R1: The index of an entry is `pcw[8:0] XOR pcw[17:9]`, where `pcw` is the instruction address bits [19:2]. Two addresses with the same index share one counter.
- R2: After reset, `ready` stays low for exactly 512 cycles while the array is swept. It then rises and stays high until the next reset.
- R3: After the sweep, every counter holds 128, so a lookup of any untouched entry returns NORMAL.
- R4: A lookup presented with `lk_valid` in cycle t yields `lk_out_valid` high and `lk_class` valid in cycle t+1. `lk_out_valid` is low in the cycle after a cycle with no lookup.
- R5: An update with `upd_reuse=1` adds one to the indexed counter, and an update with `upd_reuse=0` (first touch) subtracts one.
- R6: Counters saturate at 255 and at 0 and never wrap.
- R7: The class encoding is BYPASS=0 for counts 0..15, USELESS=1 for 16..95, NORMAL=2 for 96..159, USEFUL=3 for 160..239, and REUSE=4 for 240..255.
- R8: When a lookup and an update hit the same entry in the same cycle, the lookup returns the class of the value before the update.
- R9: While `ready` is low, updates have no effect, and lookups return NORMAL.
- R10: An update changes only its own entry. Other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pcw | input | 18 | Lookup instruction address bits [19:2] |
| upd_valid | input | 1 | Training event |
| upd_pcw | input | 18 | Training instruction address bits [19:2] |
| upd_reuse | input | 1 | 1 = reuse event, 0 = first-touch event |
| ready | output | 1 | High once the array sweep has finished |
| lk_out_valid | output | 1 | Lookup result valid |
| lk_class | output | 3 | Reuse class of the looked-up entry |

## Verification
The hardest situations to reach are the exact threshold crossings and the two saturation points. Each of them lies dozens of training events away from the start value of 128.

The stimulus table steps a single entry through every boundary: 159/160, 239/240, 255 with overshoot, then back down through 95/96, 16/15, and 0 with undershoot. A lookup after each stretch confirms the class. A wrap at either end would show up as a wrong class in the following row.

Separate directed stimulus targets entry 0 with updates during the sweep. It then places a same-cycle lookup and update on an entry held at 159, one step below a class boundary.

// File: rtl/rft_pkg.sv
package rft_pkg;

    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        CLS_BYPASS  = 3'd0,
        CLS_USELESS = 3'd1,
        CLS_NORMAL  = 3'd2,
        CLS_USEFUL  = 3'd3,
        CLS_REUSE   = 3'd4
    } reuse_cls_e;

    // lowest count of each class above BYPASS
    localparam logic [CNT_W-1:0] LIM_USELESS = 8'd16;
    localparam logic [CNT_W-1:0] LIM_NORMAL  = 8'd96;
    localparam logic [CNT_W-1:0] LIM_USEFUL  = 8'd160;
    localparam logic [CNT_W-1:0] LIM_REUSE   = 8'd240;

    localparam logic [CNT_W-1:0] CNT_START   = 8'd128;

endpackage

// File: rtl/rft_hash.sv
module rft_hash #(
    parameter int IDX_W = 9
) (
    input  logic [2*IDX_W-1:0] pcw,
    output logic [IDX_W-1:0]   idx
);
    // fold the low half of the word address onto the high half
    assign idx = pcw[IDX_W-1:0] ^ pcw[2*IDX_W-1:IDX_W];
endmodule

// File: rtl/rft_classify.sv
module rft_classify
    import rft_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    output reuse_cls_e       cls
);
    always_comb begin
        if (cnt >= LIM_REUSE)        cls = CLS_REUSE;
        else if (cnt >= LIM_USEFUL)  cls = CLS_USEFUL;
        else if (cnt >= LIM_NORMAL)  cls = CLS_NORMAL;
        else if (cnt >= LIM_USELESS) cls = CLS_USELESS;
        else                         cls = CLS_BYPASS;
    end
endmodule

// File: rtl/rft_sat_step.sv
module rft_sat_step #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        if (up) nxt = (cur == TOP) ? cur : cur + ONE;
        else    nxt = (cur == BOT) ? cur : cur - ONE;
    end
endmodule

// File: rtl/reuse_filter_table.sv
module reuse_filter_table
    import rft_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [2*IDX_W-1:0] lk_pcw,
    input  logic               upd_valid,
    input  logic [2*IDX_W-1:0] upd_pcw,
    input  logic               upd_reuse,
    output logic               ready,
    output logic               lk_out_valid,
    output logic [2:0]         lk_class
);
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_SERVE = 1'b1
    } rft_state_e;

    rft_state_e state_q, state_d;
    logic [IDX_W-1:0] sweep_idx_q;

    logic [CNT_W-1:0] table_q [DEPTH];

    logic [IDX_W-1:0] lk_idx, upd_idx;
    logic [CNT_W-1:0] lk_cnt, upd_cur, upd_nxt;
    reuse_cls_e       lk_cls_now;

    logic             sweep_wr, train_wr;
    reuse_cls_e       cls_q;
    logic             out_valid_q;

    rft_hash #(.IDX_W(IDX_W)) u_hash_lk  (.pcw(lk_pcw),  .idx(lk_idx));
    rft_hash #(.IDX_W(IDX_W)) u_hash_upd (.pcw(upd_pcw), .idx(upd_idx));

    assign lk_cnt  = table_q[lk_idx];
    assign upd_cur = table_q[upd_idx];

    rft_classify u_cls (.cnt(lk_cnt), .cls(lk_cls_now));

    rft_sat_step #(.W(CNT_W)) u_step (
        .cur (upd_cur),
        .up  (upd_reuse),
        .nxt (upd_nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_SWEEP;
            sweep_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_SWEEP) sweep_idx_q <= sweep_idx_q + 1'b1;
        end
    end

    // next state: SWEEP_DONE after the last entry is written
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SWEEP: if (sweep_idx_q == LAST_IDX) state_d = ST_SERVE;
            ST_SERVE: state_d = ST_SERVE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        sweep_wr = 1'b0;
        train_wr = 1'b0;
        ready    = 1'b0;
        unique case (state_q)
            ST_SWEEP: sweep_wr = 1'b1;
            ST_SERVE: begin
                ready    = 1'b1;
                train_wr = upd_valid;
            end
        endcase
    end

    // counter array: one write per cycle, reads see pre-write contents
    always_ff @(posedge clk) begin
        if (sweep_wr)      table_q[sweep_idx_q] <= CNT_START;
        else if (train_wr) table_q[upd_idx]     <= upd_nxt;
    end

    // registered lookup result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            cls_q       <= CLS_NORMAL;
        end else begin
            out_valid_q <= lk_valid;
            if (lk_valid) cls_q <= ready ? lk_cls_now : CLS_NORMAL;
        end
    end

    assign lk_out_valid = out_valid_q;
    assign lk_class     = cls_q;

endmodule

// File: rtl/rft_chk.sv
module rft_chk #(
    parameter int IDX_W = 9
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lk_valid,
    input logic       lk_out_valid,
    input logic [2:0] lk_class,
    input logic       ready
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W+1:0] low_cycles;
    always_ff @(posedge clk) begin
        if (!rst_n)      low_cycles <= '0;
        else if (!ready) low_cycles <= low_cycles + 1'b1;
    end

    // R2
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R2
    sweep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_cycles == (IDX_W+2)'(DEPTH)));

    // R4
    lk_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_out_valid);

    // R4
    lk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_out_valid);

    // R7
    cls_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_out_valid |-> (lk_class <= 3'd4));

    // R9
    sweep_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !ready) |=> (lk_class == 3'd2));
endmodule

bind reuse_filter_table rft_chk #(.IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_out_valid (lk_out_valid),
    .lk_class     (lk_class),
    .ready        (ready)
);

// File: tb/sim_reuse_filter_table.sv
`timescale 1ns/1ps
module sim_reuse_filter_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [17:0] lk_pcw = '0;
    logic        upd_valid = 1'b0;
    logic [17:0] upd_pcw = '0;
    logic        upd_reuse = 1'b0;
    logic        ready, lk_out_valid;
    logic [2:0]  lk_class;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    reuse_filter_table u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pcw(lk_pcw),
        .upd_valid(upd_valid), .upd_pcw(upd_pcw), .upd_reuse(upd_reuse),
        .ready(ready), .lk_out_valid(lk_out_valid), .lk_class(lk_class)
    );

    // {steps[11:4], dir reuse[3], expected class[2:0]} on entry of word 1 (index 1)
    localparam logic [11:0] VEC [17] = '{
        {8'd31, 1'b1, 3'd2}, {8'd1,  1'b1, 3'd3}, {8'd79, 1'b1, 3'd3},
        {8'd1,  1'b1, 3'd4}, {8'd15, 1'b1, 3'd4}, {8'd10, 1'b1, 3'd4},
        {8'd16, 1'b0, 3'd3}, {8'd79, 1'b0, 3'd3}, {8'd1,  1'b0, 3'd2},
        {8'd63, 1'b0, 3'd2}, {8'd1,  1'b0, 3'd1}, {8'd79, 1'b0, 3'd1},
        {8'd1,  1'b0, 3'd0}, {8'd15, 1'b0, 3'd0}, {8'd5,  1'b0, 3'd0},
        {8'd16, 1'b1, 3'd1}, {8'd1,  1'b1, 3'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic upd(input logic [17:0] pcw, input logic up);
        @(negedge clk);
        upd_valid = 1'b1; upd_pcw = pcw; upd_reuse = up;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic look(input logic [17:0] pcw, output logic [2:0] cls);
        @(negedge clk);
        lk_valid = 1'b1; lk_pcw = pcw;
        @(negedge clk);
        lk_valid = 1'b0;
        cls = lk_class;
        check("R4 valid", lk_out_valid, 1);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] c;
        int lowcnt;
        repeat (3) @(negedge clk);
        check("R2 reset ready", ready, 0);
        rst_n = 1'b1;
        // sweep: count low cycles, poke entry 0 with updates, look it up
        lowcnt = 0;
        while (!ready && lowcnt < 2000) begin
            lowcnt++;
            upd_valid = (lowcnt >= 10 && lowcnt < 50);
            upd_pcw   = 18'd0;
            upd_reuse = 1'b0;
            lk_valid  = (lowcnt == 60);
            lk_pcw    = 18'd0;
            if (lowcnt == 61) begin
                check("R9 sweep lookup", lk_class, 2);
                check("R4 out valid", lk_out_valid, 1);
            end
            if (lowcnt == 62) check("R4 idle", lk_out_valid, 0);
            @(negedge clk);
        end
        upd_valid = 1'b0; lk_valid = 1'b0;
        check("R2 sweep length", lowcnt, 512);
        look(18'd0, c);
        check("R9 updates ignored", c, 2);
        look(18'd77, c);
        check("R3 start class", c, 2);

        // table walk on word address 1
        foreach (VEC[i]) begin
            for (int k = 0; k < int'(VEC[i][11:4]); k++) upd(18'd1, VEC[i][3]);
            look(18'd1, c);
            check($sformatf("R5/R6/R7 row %0d", i), c, VEC[i][2:0]);
        end
        // entry now 17; alias via word 1<<9 (index 1)
        look(18'd512, c);
        check("R1 alias", c, 1);
        look(18'd2, c);
        check("R10 untouched neighbour", c, 2);

        // R8: entry of word 64 to 159, then same-cycle lookup and update
        for (int k = 0; k < 31; k++) upd(18'd64, 1'b1);
        @(negedge clk);
        lk_valid = 1'b1; lk_pcw = 18'd64;
        upd_valid = 1'b1; upd_pcw = 18'd64; upd_reuse = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0; upd_valid = 1'b0;
        check("R8 pre-update", lk_class, 2);
        look(18'd64, c);
        check("R8 post-update", c, 3);
        look(18'd1, c);
        check("R10 other entry kept", c, 1);

        // reset again: ready drops, entry returns to start
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R2 ready after reset", ready, 0);
        wait (ready);
        look(18'd64, c);
        check("R3 restart class", c, 2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule